// File: doc/BRIEF.md
# Fractional PLL Control Register Block

This block is the digital control front end of a fractional-N clock synthesizer. Software reaches it through two 32-bit registers on a simple bus with valid, write and address signals. The block drives the analog core's power-down and bypass controls. It also drives the output divider code and the feedback dividers that are currently in use.

The feedback dividers are double-buffered. Writes to the divider register only change a staged copy. The active dividers take the staged values when software raises a reload request. The block answers that request with an acknowledge bit a fixed number of cycles later. Software then drops the request, and the acknowledge drops after it. While the core is powered down or bypassed, there is no handshake: the active dividers simply follow the staged copy.

A cycle-count model stands in for loop lock. Lock is reported a fixed number of cycles after power-down is released, and it is lost as soon as power-down is set again. The output division ratio is (output code + 1) × 2. The feedback multiplier applied to eight times the reference is 1 + integer code + fraction / 2^24. The rate arithmetic itself is left to software.

Top module: `fpll_ctrl`

## Requirements
- R1: After reset, the control register (offset 0x0) reads 0x0008_0000 and the divider register (offset 0x4) reads 0. The power-down output is 1, the bypass output is 0, and all divider outputs are 0.
- R2: Control register fields are power-down at bit 19, bypass at bit 14, reload request at bit 12 and output divider code at bits 4:0. All of them read back as written, and unused bits read 0. The power-down, bypass and output-code ports follow a write on the next cycle.
- R3: The divider register holds the fraction at bits 30:7 and the integer code at bits 6:0, and reads back the staged values. While powered up and not bypassed, writing it leaves the active divider ports unchanged.
- R4: While powered up and not bypassed, the active dividers take the staged values, and acknowledge (control bit 11) is set, exactly RELOAD_LAT cycles after the request bit is written to 1.
- R5: Once the request bit is cleared, the acknowledge bit reads 0 within one cycle.
- R6: While power-down or bypass is set, the active dividers take the staged values on the cycle after they are staged, and acknowledge is never set.
- R7: Lock (control bit 31) reads 0 while powered down. It becomes 1 exactly LOCK_LAT cycles after power-down is cleared.
- R8: Setting power-down clears lock on the following cycle.
- R9: Writes to bits 31 and 11 of the control register have no effect.
- R10: Bus accesses to offsets other than 0x0 and 0x4 change nothing and read 0. Read data appears on bus_rdata the cycle after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pwr_down | output | 1 | Analog core power-down |
| bypass | output | 1 | Reference bypass |
| out_div | output | 5 | Output divider code |
| fb_int | output | 7 | Active integer feedback code |
| fb_frac | output | 24 | Active fractional feedback value |

## Verification
Some properties are checked on every cycle by the in-module assertions. Acknowledge rises only while a request is held and the core is running, and it falls once the request is gone. Lock never survives a cycle of power-down and only rises after power-down was low. The active dividers never move except on a rising acknowledge or while powered down or bypassed. Other behaviour is shown only by the bench's scenarios: the exact reload and lock latencies, field positions and reset values, and the ignored read-only bits and offsets. The bench covers these with sweeps over every output code and every integer code.

// File: rtl/fpll_ctrl.sv
module fpll_ctrl #(
  parameter int RELOAD_LAT = 4,
  parameter int LOCK_LAT   = 16,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              pwr_down,
  output logic              bypass,
  output logic [4:0]        out_div,
  output logic [6:0]        fb_int,
  output logic [23:0]       fb_frac
);
  localparam int RCW = $clog2(RELOAD_LAT + 1) + 1;
  localparam int LCW = $clog2(LOCK_LAT + 1) + 1;
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_DIV  = ADDR_W'(4);

  logic pd_q, byp_q, req_q, ack_q, lock_q;
  logic [4:0]  odiv_q;
  logic [6:0]  int_stg, int_act;
  logic [23:0] frac_stg, frac_act;
  logic [RCW-1:0] rcnt;
  logic [LCW-1:0] lcnt;
  logic [31:0] ctrl_word, div_word;

  wire wr_ctrl = bus_valid && bus_write && (bus_addr == OFS_CTRL);
  wire wr_div  = bus_valid && bus_write && (bus_addr == OFS_DIV);
  wire rd_en   = bus_valid && !bus_write;
  wire idle_core = pd_q || byp_q;

  assign ctrl_word = {lock_q, 11'b0, pd_q, 4'b0, byp_q, 1'b0, req_q, ack_q, 6'b0, odiv_q};
  assign div_word  = {1'b0, frac_stg, int_stg};

  assign pwr_down = pd_q;
  assign bypass   = byp_q;
  assign out_div  = odiv_q;
  assign fb_int   = int_act;
  assign fb_frac  = frac_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pd_q <= 1'b1; byp_q <= 1'b0; req_q <= 1'b0; odiv_q <= '0;
      int_stg <= '0; frac_stg <= '0;
    end else begin
      if (wr_ctrl) begin
        pd_q   <= bus_wdata[19];
        byp_q  <= bus_wdata[14];
        req_q  <= bus_wdata[12];
        odiv_q <= bus_wdata[4:0];
      end
      if (wr_div) begin
        frac_stg <= bus_wdata[30:7];
        int_stg  <= bus_wdata[6:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (rd_en) begin
      if (bus_addr == OFS_CTRL)     bus_rdata <= ctrl_word;
      else if (bus_addr == OFS_DIV) bus_rdata <= div_word;
      else                          bus_rdata <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q <= 1'b0; rcnt <= '0; int_act <= '0; frac_act <= '0;
    end else begin
      if (idle_core) begin
        int_act  <= int_stg;
        frac_act <= frac_stg;
        rcnt     <= '0;
      end else if (req_q && !ack_q) begin
        if (rcnt == RCW'(RELOAD_LAT - 1)) begin
          ack_q    <= 1'b1;
          int_act  <= int_stg;
          frac_act <= frac_stg;
          rcnt     <= '0;
        end else begin
          rcnt <= rcnt + RCW'(1);
        end
      end else begin
        rcnt <= '0;
      end
      if (!req_q) ack_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= 1'b0; lcnt <= '0;
    end else if (pd_q) begin
      lock_q <= 1'b0; lcnt <= '0;
    end else if (!lock_q) begin
      if (lcnt == LCW'(LOCK_LAT - 1)) lock_q <= 1'b1;
      else                            lcnt <= lcnt + LCW'(1);
    end
  end

  // R4
  ack_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(req_q) && !$past(idle_core));

  // R5
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && !req_q) |=> !ack_q);

  // R8
  lock_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_q |=> !lock_q);

  // R7
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> !$past(pd_q));

  // R3
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({int_act, frac_act} != $past({int_act, frac_act})) |-> ($rose(ack_q) || $past(idle_core)));
endmodule

// File: tb/sim_fpll_ctrl.sv
module sim_fpll_ctrl;
  localparam int RL = 4;
  localparam int LL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic pwr_down, bypass;
  logic [4:0] out_div;
  logic [6:0] fb_int;
  logic [23:0] fb_frac;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fpll_ctrl #(.RELOAD_LAT(RL), .LOCK_LAT(LL), .ADDR_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwr_down(pwr_down), .bypass(bypass), .out_div(out_div),
    .fb_int(fb_int), .fb_frac(fb_frac));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    logic [31:0] r;
    logic [23:0] last_f;
    logic [6:0]  last_i;
    last_f = '0; last_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R1 pd port", 32'(pwr_down), 32'd1);
    check("R1 bypass port", 32'(bypass), 32'd0);
    check("R1 dividers", {1'b0, fb_frac, fb_int}, 32'd0);
    rd(4'h0, r); check("R1 ctrl", r, 32'h0008_0000);
    rd(4'h4, r); check("R1 div", r, 32'd0);

    // R6: powered down, active follows staged for every integer code
    for (int i = 0; i < 128; i++) begin
      logic [23:0] f;
      f = 24'((i * 32'h2A5F3 + 7) & 32'hFF_FFFF);
      wr(4'h4, {1'b0, f, 7'(i)});
      @(negedge clk);
      check("R6 int follows", 32'(fb_int), 32'(i));
      check("R6 frac follows", 32'(fb_frac), 32'(f));
      if (i % 16 == 5) begin
        rd(4'h4, r); check("R3 staged readback", r, {1'b0, f, 7'(i)});
      end
      last_f = f; last_i = 7'(i);
    end
    rd(4'h0, r); check("R6 no ack while pd", 32'(r[11]), 32'd0);

    // R2: every output code (ratio (c+1)*2)
    for (int c = 0; c < 32; c++) begin
      wr(4'h0, 32'h0008_0000 | 32'(c));
      check($sformatf("R2 out_div ratio %0d", (c + 1) * 2), 32'(out_div), 32'(c));
      rd(4'h0, r); check("R2 ctrl readback", r, 32'h0008_0000 | 32'(c));
    end
    wr(4'h0, 32'h0008_5000);
    check("R2 bypass port", 32'(bypass), 32'd1);
    rd(4'h0, r); check("R2 byp/req readback", r, 32'h0008_5000);
    wr(4'h0, 32'h8008_0800);
    rd(4'h0, r); check("R9 ro bits ignored", r, 32'h0008_0000);

    // R7: power up, lock latency
    wr(4'h0, 32'h0);
    check("R2 pd port cleared", 32'(pwr_down), 32'd0);
    repeat (LL - 1) @(negedge clk);
    rd(4'h0, r); check("R7 lock not early", 32'(r[31]), 32'd0);
    rd(4'h0, r); check("R7 lock on time", 32'(r[31]), 32'd1);

    // R3: staging does not move active dividers
    wr(4'h4, {1'b0, 24'h123456, 7'd45});
    repeat (5) @(negedge clk);
    check("R3 int held", 32'(fb_int), 32'(last_i));
    check("R3 frac held", 32'(fb_frac), 32'(last_f));
    rd(4'h4, r); check("R3 staged", r, {1'b0, 24'h123456, 7'd45});

    // R4: reload handshake latency
    wr(4'h0, 32'h0000_1000);
    repeat (RL - 1) @(negedge clk);
    check("R4 not early", 32'(fb_int), 32'(last_i));
    @(negedge clk);
    check("R4 int loaded", 32'(fb_int), 32'd45);
    check("R4 frac loaded", 32'(fb_frac), 32'h123456);
    rd(4'h0, r); check("R4 ack set", r, 32'h8000_1800);

    // R5
    wr(4'h0, 32'h0);
    rd(4'h0, r);
    rd(4'h0, r); check("R5 ack dropped", r, 32'h8000_0000);

    // R8
    wr(4'h0, 32'h0008_0000);
    @(negedge clk);
    rd(4'h0, r); check("R8 lock lost", r, 32'h0008_0000);

    // R6: bypass path
    wr(4'h0, 32'h0000_4000);
    wr(4'h4, {1'b0, 24'hABCDEF, 7'd99});
    @(negedge clk);
    check("R6 bypass int", 32'(fb_int), 32'd99);
    check("R6 bypass frac", 32'(fb_frac), 32'hABCDEF);
    wr(4'h0, 32'h0000_5000);
    repeat (RL + 3) @(negedge clk);
    rd(4'h0, r); check("R6 no ack in bypass", r & 32'h7FFF_FFFF, 32'h0000_5000);

    // R10
    wr(4'h2, 32'hFFFF_FFFF);
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h4, r); check("R10 div untouched", r, {1'b0, 24'hABCDEF, 7'd99});
    rd(4'h0, r); check("R10 ctrl untouched", r & 32'h7FFF_FFFF, 32'h0000_5000);
    rd(4'h8, r); check("R10 unmapped reads 0", r, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule